// File: doc/BRIEF.md
# Sixteen-bit timer channel with compare, overflow and output flags

This block is one channel of a general-purpose timer. A 16-bit counter advances by one on every cycle in which the channel is enabled and the prescaler supplies a tick. It counts up or down, chosen by a direction input. A synchronous load input presets the count. Each step is checked against a compare value and against the wrap boundary of the current direction.

Two sticky flags record these events. The overflow flag is set on a wrap: 0xFFFF to 0x0000 when counting up, 0x0000 to 0xFFFF when counting down. The compare flag is set when a step starts from a count equal to the compare value. Software clears each flag by writing one to it. Each flag has its own mask bit for the interrupt line.

An output flag is driven by a 3-bit mode field. Its modes include one that sets the flag on a compare and clears it on a rollover, for PWM-like waveforms. A compare value of 0xFFFF gives a compare event in the same cycle as the up-count overflow.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count is 0x0000 and the overflow, compare and output flags and the interrupt are all low.
- R2: The count changes by one only in a cycle with `ch_en`=1, `tick`=1 and `load`=0, rising by one when `count_down`=0 and falling by one when `count_down`=1; in every other cycle without a load it holds its value.
- R3: Counting up from 0xFFFF, the count wraps to 0x0000 at the same clock edge at which `ovf_flag` becomes 1.
- R4: Counting down from 0x0000, the count wraps to 0xFFFF at the same clock edge at which `ovf_flag` becomes 1.
- R5: `ovf_flag` and `cmp_flag` stay set until a cycle with the matching clear input at 1; a new event in that same cycle keeps the flag set.
- R6: `cmp_flag` is set at the edge of a counting step whose starting count equals `cmp_val`.
- R7: With `cmp_val`=0xFFFF, counting up, `cmp_flag` and `ovf_flag` rise at the same edge.
- R8: `irq` is high, in the same cycle, exactly when (`ovf_flag` and `ovf_ie`) or (`cmp_flag` and `cmp_ie`) holds.
- R9: `load`=1 writes `load_val` into the count and raises no overflow or compare event in that cycle, even if `ch_en` and `tick` are high.
- R10: The `out_mode` encodings 000 and 101 drive the output flag low and high. Encoding 111 holds the output flag.
- R11: `out_mode` encodings 001, 010 and 011 set, clear or toggle the output flag on a compare event. Encoding 100 toggles it on a wrap event.
- R12: `out_mode`=110 sets the output flag on a compare event and clears it on a wrap event. When both events occur in the same step, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 1 | Channel enable |
| tick | input | 1 | Prescaler tick, one-cycle pulse |
| count_down | input | 1 | 0 = count up, 1 = count down |
| load | input | 1 | Synchronous preset of the count |
| load_val | input | 16 | Value written by `load` |
| cmp_val | input | 16 | Compare value |
| out_mode | input | 3 | Output flag mode |
| ovf_ie | input | 1 | Overflow interrupt mask (1 = enabled) |
| cmp_ie | input | 1 | Compare interrupt mask (1 = enabled) |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| cmp_clr | input | 1 | Write-one clear of the compare flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| out_flag | output | 1 | Mode-driven output flag |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong count shows up on `count` at the first edge after the faulty step. A wrong wrap boundary or a wrong compare test shows up on the flags at the same edge, so wrap cases are started from a preloaded count. A flag that stays set or clears when it should not differs from the expected value at the next sample of its port. An output-mode fault appears on `out_flag` one edge after the compare or wrap event that should have moved it. The case where compare and wrap fall in the same step is exercised in mode 110, where the priority between set and clear is visible.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

   typedef enum logic [2:0] {
      OM_LOW      = 3'b000,
      OM_SET      = 3'b001,
      OM_CLR      = 3'b010,
      OM_TGL      = 3'b011,
      OM_TGL_WRAP = 3'b100,
      OM_HIGH     = 3'b101,
      OM_PWM      = 3'b110,
      OM_HOLD     = 3'b111
   } out_mode_e;

   typedef struct packed {
      logic step;
      logic wrap;
      logic match;
   } tmr_evt_t;

endpackage

// File: rtl/tmr_chan_counter.sv
module tmr_chan_counter
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit DOWN_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ch_en,
   input  logic             tick,
   input  logic             count_down,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] count,
   output tmr_evt_t         evt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_MIN = '0;
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             dn;
   logic             step;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   generate
      if (DOWN_EN) begin : g_bidir
         assign dn = count_down;
      end else begin : g_up_only
         assign dn = 1'b0;
      end
   endgenerate

   assign step = ch_en & tick & ~load;

   always_comb begin
      evt.step  = step;
      evt.wrap  = step & (dn ? (cnt_q == CNT_MIN) : (cnt_q == CNT_MAX));
      evt.match = step & (cnt_q == cmp_val);
   end

   always_comb begin
      cnt_d = cnt_q;
      if (load)      cnt_d = load_val;
      else if (step) cnt_d = dn ? (cnt_q - CNT_ONE) : (cnt_q + CNT_ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count = cnt_q;

endmodule

// File: rtl/tmr_chan_flags.sv
module tmr_chan_flags
   import tmr_chan_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
)(
   input  logic     clk,
   input  logic     rst_n,
   input  tmr_evt_t evt,
   input  logic     ovf_clr,
   input  logic     cmp_clr,
   input  logic     ovf_ie,
   input  logic     cmp_ie,
   output logic     ovf_flag,
   output logic     cmp_flag,
   output logic     irq
);

   logic ovf_q, cmp_q;
   logic irq_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         cmp_q <= 1'b0;
      end else begin
         if (evt.wrap)     ovf_q <= 1'b1;
         else if (ovf_clr) ovf_q <= 1'b0;
         if (evt.match)    cmp_q <= 1'b1;
         else if (cmp_clr) cmp_q <= 1'b0;
      end
   end

   assign irq_c = (ovf_q & ovf_ie) | (cmp_q & cmp_ie);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate

   assign ovf_flag = ovf_q;
   assign cmp_flag = cmp_q;

endmodule

// File: rtl/tmr_chan_outgen.sv
module tmr_chan_outgen
   import tmr_chan_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  tmr_evt_t  evt,
   input  out_mode_e mode,
   output logic      out_flag
);

   logic out_q, out_d;

   always_comb begin
      out_d = out_q;
      unique case (mode)
         OM_LOW:      out_d = 1'b0;
         OM_HIGH:     out_d = 1'b1;
         OM_SET:      if (evt.match) out_d = 1'b1;
         OM_CLR:      if (evt.match) out_d = 1'b0;
         OM_TGL:      if (evt.match) out_d = ~out_q;
         OM_TGL_WRAP: if (evt.wrap)  out_d = ~out_q;
         OM_PWM: begin
            if (evt.wrap)       out_d = 1'b0;
            else if (evt.match) out_d = 1'b1;
         end
         OM_HOLD:     out_d = out_q;
         default:     out_d = out_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
   end

   assign out_flag = out_q;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit DOWN_EN = 1'b1,
   parameter bit IRQ_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ch_en,
   input  logic             tick,
   input  logic             count_down,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [2:0]       out_mode,
   input  logic             ovf_ie,
   input  logic             cmp_ie,
   input  logic             ovf_clr,
   input  logic             cmp_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             cmp_flag,
   output logic             out_flag,
   output logic             irq
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tmr_chan: CNT_W must lie in 2..32");
      end
   endgenerate

   tmr_evt_t evt;

   tmr_chan_counter #(.CNT_W(CNT_W), .DOWN_EN(DOWN_EN)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ch_en      (ch_en),
      .tick       (tick),
      .count_down (count_down),
      .load       (load),
      .load_val   (load_val),
      .cmp_val    (cmp_val),
      .count      (count),
      .evt        (evt)
   );

   tmr_chan_flags #(.IRQ_REG(IRQ_REG)) u_flg (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .ovf_clr  (ovf_clr),
      .cmp_clr  (cmp_clr),
      .ovf_ie   (ovf_ie),
      .cmp_ie   (cmp_ie),
      .ovf_flag (ovf_flag),
      .cmp_flag (cmp_flag),
      .irq      (irq)
   );

   tmr_chan_outgen u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .mode     (out_mode_e'(out_mode)),
      .out_flag (out_flag)
   );

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int CNT_W   = 16,
   parameter bit DOWN_EN = 1'b1,
   parameter bit IRQ_REG = 1'b0
)(
   input logic             clk,
   input logic             rst_n,
   input logic             ch_en,
   input logic             tick,
   input logic             count_down,
   input logic             load,
   input logic [CNT_W-1:0] cmp_val,
   input logic [2:0]       out_mode,
   input logic             ovf_ie,
   input logic             cmp_ie,
   input logic             ovf_clr,
   input logic             cmp_clr,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             cmp_flag,
   input logic             out_flag,
   input logic             irq
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(ch_en && tick)) |=> (count == $past(count)));   // R2

   AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && tick && !load && !count_down && count == CMAX)
      |=> (count == '0 && ovf_flag));                               // R3

   AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (DOWN_EN && ch_en && tick && !load && count_down && count == '0)
      |=> (count == CMAX && ovf_flag));                             // R4

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);                         // R5

   AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !cmp_clr) |=> cmp_flag);                         // R5

   AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && tick && !load && count == cmp_val) |=> cmp_flag);   // R6

   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ovf_flag && !ovf_clr) |=> !ovf_flag);               // R9

   AST_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode == 3'b000) |=> !out_flag);                          // R10

   AST_PWM_WRAP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode == 3'b110 && ch_en && tick && !load && !count_down && count == CMAX)
      |=> !out_flag);                                               // R12

   generate
      if (!IRQ_REG) begin : g_irq_chk
         AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ovf_flag && ovf_ie) && !(cmp_flag && cmp_ie)) |-> !irq); // R8
      end
   endgenerate

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .DOWN_EN(DOWN_EN), .IRQ_REG(IRQ_REG)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ch_en      (ch_en),
   .tick       (tick),
   .count_down (count_down),
   .load       (load),
   .cmp_val    (cmp_val),
   .out_mode   (out_mode),
   .ovf_ie     (ovf_ie),
   .cmp_ie     (cmp_ie),
   .ovf_clr    (ovf_clr),
   .cmp_clr    (cmp_clr),
   .count      (count),
   .ovf_flag   (ovf_flag),
   .cmp_flag   (cmp_flag),
   .out_flag   (out_flag),
   .irq        (irq)
);

// File: tb/tmr_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_chan_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ch_en = 0, tick = 0, count_down = 0, load = 0;
   logic [15:0] load_val = '0, cmp_val = '0;
   logic [2:0]  out_mode = '0;
   logic        ovf_ie = 0, cmp_ie = 0, ovf_clr = 0, cmp_clr = 0;
   logic [15:0] count;
   logic        ovf_flag, cmp_flag, out_flag, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tmr_chan dut_i (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .tick(tick), .count_down(count_down),
      .load(load), .load_val(load_val), .cmp_val(cmp_val), .out_mode(out_mode),
      .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
      .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .out_flag(out_flag), .irq(irq)
   );

   typedef struct {
      string       tag;
      logic [15:0] cnt;
      logic        ovf, cmp, out, irq;
   } exp_t;

   exp_t sb_q[$];

   // model state, derived from the requirements
   logic [15:0] m_cnt = '0;
   logic        m_ovf = 0, m_cmp = 0, m_out = 0;

   task automatic cyc(input string tag);
      logic st, wr, mt;
      exp_t e;
      st = ch_en && tick && !load;
      wr = st && (count_down ? (m_cnt == 16'h0000) : (m_cnt == 16'hFFFF));
      mt = st && (m_cnt == cmp_val);
      case (out_mode)
         3'b000: m_out = 1'b0;
         3'b101: m_out = 1'b1;
         3'b001: if (mt) m_out = 1'b1;
         3'b010: if (mt) m_out = 1'b0;
         3'b011: if (mt) m_out = ~m_out;
         3'b100: if (wr) m_out = ~m_out;
         3'b110: if (wr) m_out = 1'b0; else if (mt) m_out = 1'b1;
         default: ;
      endcase
      if (load)    m_cnt = load_val;
      else if (st) m_cnt = count_down ? m_cnt - 16'd1 : m_cnt + 16'd1;
      if (wr) m_ovf = 1'b1; else if (ovf_clr) m_ovf = 1'b0;
      if (mt) m_cmp = 1'b1; else if (cmp_clr) m_cmp = 1'b0;
      e.tag = tag; e.cnt = m_cnt; e.ovf = m_ovf; e.cmp = m_cmp; e.out = m_out;
      e.irq = (m_ovf && ovf_ie) || (m_cmp && cmp_ie);
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   task automatic preload(input logic [15:0] v, input string tag);
      load = 1; load_val = v;
      cyc(tag);
      load = 0;
   endtask

   task automatic clr_flags(input string tag);
      ch_en = 0; ovf_clr = 1; cmp_clr = 1;
      cyc(tag);
      ovf_clr = 0; cmp_clr = 0;
   endtask

   // monitor: pops one expected item per cycle, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (count !== e.cnt || ovf_flag !== e.ovf || cmp_flag !== e.cmp ||
                out_flag !== e.out || irq !== e.irq) begin
               errors++;
               $display("FAIL %s: cnt/ovf/cmp/out/irq actual %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                        e.tag, count, ovf_flag, cmp_flag, out_flag, irq,
                        e.cnt, e.ovf, e.cmp, e.out, e.irq);
            end
         end
      end
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      checks++;   // R1 reset state
      if (count !== 16'h0 || ovf_flag !== 0 || cmp_flag !== 0 || out_flag !== 0 || irq !== 0) begin
         errors++;
         $display("FAIL R1: cnt/ovf/cmp/out/irq actual %h/%b/%b/%b/%b expected 0000/0/0/0/0",
                  count, ovf_flag, cmp_flag, out_flag, irq);
      end
      cmp_val = 16'h8000;
      // R2: counting gated by enable and tick
      ch_en = 1; tick = 1; run(5, "R2 up steps");
      tick = 0; run(2, "R2 no tick");
      ch_en = 0; tick = 1; run(2, "R2 disabled");
      ch_en = 1; count_down = 1; run(2, "R2 down steps");
      count_down = 0;
      // R9: load raises no events even when a step would match or wrap
      cmp_val = 16'hFFFD; preload(16'hFFFD, "R9 load quiet");
      load = 1; load_val = 16'hFFFF; cmp_val = 16'hFFFF; cyc("R9 load from FFFF"); load = 0;
      // R6 / R3: compare then up wrap
      cmp_val = 16'hFFFD; preload(16'hFFFC, "R6 preload");
      run(4, "R6 R3 up wrap");
      // R5: sticky and write-one clear
      ch_en = 0; run(2, "R5 sticky");
      ovf_clr = 1; cyc("R5 ovf clear"); ovf_clr = 0;
      cmp_clr = 1; cyc("R5 cmp clear"); cmp_clr = 0;
      preload(16'hFFFF, "R5 preload");
      ch_en = 1; ovf_clr = 1; cyc("R5 set beats clear"); ovf_clr = 0;
      // R8: masks
      ch_en = 0;
      ovf_ie = 1; cyc("R8 ovf irq");
      ovf_ie = 0; cmp_ie = 1; cyc("R8 masked, cmp clear");
      ovf_ie = 1; cmp_ie = 0; cyc("R8 ovf irq again");
      ovf_ie = 0; cyc("R8 masked");
      // R7: compare at FFFF coincides with overflow
      clr_flags("R7 clear");
      cmp_val = 16'hFFFF; preload(16'hFFFE, "R7 preload");
      ch_en = 1; cmp_ie = 1; run(3, "R7 cmp with ovf"); cmp_ie = 0;
      // R4: down wrap
      clr_flags("R4 clear");
      cmp_val = 16'hFFFE; preload(16'h0001, "R4 preload");
      ch_en = 1; count_down = 1; run(4, "R4 down wrap");
      count_down = 0;
      // R10 / R11: output modes
      ch_en = 0; out_mode = 3'b101; cyc("R10 high");
      out_mode = 3'b111; run(2, "R10 hold");
      out_mode = 3'b000; cyc("R10 low");
      cmp_val = 16'h0102; preload(16'h0100, "R11 preload");
      ch_en = 1; out_mode = 3'b001; run(4, "R11 set on cmp");
      ch_en = 0; preload(16'h0100, "R11 preload");
      ch_en = 1; out_mode = 3'b010; run(4, "R11 clear on cmp");
      ch_en = 0; preload(16'h0100, "R11 preload");
      ch_en = 1; out_mode = 3'b011; run(4, "R11 toggle on cmp");
      ch_en = 0; preload(16'h0100, "R11 preload");
      ch_en = 1; run(4, "R11 toggle again");
      ch_en = 0; preload(16'hFFFE, "R11 preload");
      ch_en = 1; out_mode = 3'b100; run(4, "R11 toggle on wrap");
      // R12: PWM-like mode
      ch_en = 0; out_mode = 3'b000; cyc("R12 start low");
      cmp_val = 16'hFFFD; preload(16'hFFFB, "R12 preload");
      ch_en = 1; out_mode = 3'b110; run(6, "R12 set cmp clr wrap");
      ch_en = 0; out_mode = 3'b101; cyc("R12 force high");
      cmp_val = 16'hFFFF; preload(16'hFFFE, "R12 preload");
      ch_en = 1; out_mode = 3'b110; run(3, "R12 wrap beats cmp");
      ch_en = 0; count_down = 1; cmp_val = 16'h0005; preload(16'h0006, "R12 preload");
      ch_en = 1; run(8, "R12 down wrap clears");
      ch_en = 0; count_down = 0;
      run(2, "R2 idle tail");
      @(negedge clk); @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule